// File: doc/BRIEF.md
# Three-Wire Read Reply Transmitter

This block is the transmit half of a three-wire serial slave, in which one data line carries traffic in both directions. It watches the select, serial clock and incoming data, which are brought into the system clock domain. It collects each 9-bit frame: a data/command flag and then an 8-bit code, most significant bit first. When the frame holds a read command, it turns the shared line around and shifts out a reply that it takes from a register source. The pad logic joins `sdo` and `sdo_oe` into the tri-state line.

The command code sets the reply length. A group of short-reply codes returns 8 bits, starting on the shift edge right after the command. Code 04h first lets one idle (dummy) serial clock period pass and then returns 24 bits. The mode input `edge_sel` picks which serial clock edge samples host data. The reply is driven on the other edge, so the host can sample it on the same edge it uses for its own data.

When a command is decoded, the block shows the code on `rd_cmd` and pulses `rd_req`. The register source must have `rd_data` valid in that same system clock cycle, and the block copies it into its own shift register at that point.

Top module: `rsp3w_read_tx`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` is 0 and serial clock edges are ignored. Frame collection restarts at the next falling edge of `cs_n`.
- R2: A frame is 9 bits: a flag bit (0 = command) and then code bits 7 down to 0. With `edge_sel`=0 they are sampled on rising `sclk`; with `edge_sel`=1, on falling `sclk`.
- R3: Command codes 05h, 0Ah, 0Bh, 0Ch, 0Dh, 0Eh, 0Fh, DAh, DBh and DCh reply with `rd_data[7:0]`, MSB first. The first reply bit is driven on the first drive edge after the last command bit, with no dummy period.
- R4: Command code 04h leaves one full serial clock period undriven and then replies with `rd_data[23:0]`, MSB first.
- R5: Reply bits change only on the drive edge, which is the edge opposite the sampling edge. Between drive edges, `sdo` holds its value.
- R6: `sdo_oe` rises only on a drive edge. It falls on the drive edge that follows the last reply bit and stays low until `cs_n` rises.
- R7: A frame whose flag is 1, or whose code is not a read code, leaves `sdo_oe` at 0. Collection of the next 9-bit frame then continues within the same select.
- R8: When `cs_n` rises in the middle of a reply, `sdo_oe` drops. The next select begins with a fresh frame.
- R9: The reply word is captured when the command is decoded. Changes on `rd_data` after that point do not affect the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| sdi | input | 1 | Value received from the shared data line |
| edge_sel | input | 1 | 0: sample on rising sclk; 1: sample on falling sclk |
| rd_data | input | REPLY_W (24) | Reply word from the register source |
| rd_cmd | output | CMD_W (8) | Code of the frame just collected |
| rd_req | output | 1 | One-cycle pulse when `rd_cmd` is decoded |
| sdo | output | 1 | Reply bit toward the shared line |
| sdo_oe | output | 1 | Drive enable for the shared line |

## Verification
The assertions assume each serial clock half period lasts much longer than the synchronizer latency plus one system clock cycle. They also assume `edge_sel` changes only while `cs_n` is high, and that the decoded code lists do not overlap. The stimulus holds every serial half period at 8 system clocks and switches the mode only between selects. It takes `rd_data` from a fixed function of `rd_cmd`, which keeps the source valid in the decode cycle. The host model checks every sampling edge against queued expectations: command bits, the dummy period, each reply bit and the period after the reply. Aborted replies and mid-reply source changes are checked as separate cases.

// File: rtl/rsp3w_pkg.sv
package rsp3w_pkg;

   typedef enum logic [2:0] {
      ST_CMD    = 3'd0,
      ST_DECODE = 3'd1,
      ST_WAIT   = 3'd2,
      ST_SHIFT  = 3'd3,
      ST_DONE   = 3'd4
   } rsp_state_e;

endpackage

// File: rtl/rsp3w_sync.sv
module rsp3w_sync #(
   parameter int              STAGES  = 2,
   parameter int              W       = 1,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rsp3w_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= din;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rsp3w_edges.sv
module rsp3w_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic edge_sel,
   output logic smp_edge,
   output logic drv_edge
);

   logic sclk_prev;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign rise     = sclk_s & ~sclk_prev;
   assign fall     = ~sclk_s & sclk_prev;
   assign smp_edge = edge_sel ? fall : rise;
   assign drv_edge = edge_sel ? rise : fall;

   // R5
   edges_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_edge && drv_edge));

endmodule

// File: rtl/rsp3w_decode.sv
module rsp3w_decode #(
   parameter int                      CMD_W       = 8,
   parameter int                      N_SHORT     = 10,
   parameter logic [N_SHORT*CMD_W-1:0] SHORT_CODES = '0,
   parameter logic [CMD_W-1:0]        LONG_CODE   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] code,
   output logic             is_short,
   output logic             is_long
);

   logic [N_SHORT-1:0] hit;

   generate
      if (N_SHORT < 1) begin : g_bad_list
         $error("rsp3w_decode: N_SHORT must be at least 1");
      end
      for (genvar i = 0; i < N_SHORT; i++) begin : g_cmp
         assign hit[i] = (code == SHORT_CODES[i*CMD_W +: CMD_W]);
      end
   endgenerate

   assign is_short = |hit;
   assign is_long  = (code == LONG_CODE);

   // R7
   decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({is_short, is_long}));

endmodule

// File: rtl/rsp3w_shifter.sv
module rsp3w_shifter #(
   parameter int W       = 24,
   parameter int SHORT_W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         long_sel,
   input  logic [W-1:0] data_in,
   input  logic         shift,
   output logic         msb
);

   localparam int PAD_W = W - SHORT_W;

   logic [W-1:0] sr_q;
   logic [W-1:0] load_val;

   generate
      if (SHORT_W < 1 || SHORT_W >= W) begin : g_bad_width
         $error("rsp3w_shifter: need 1 <= SHORT_W < W");
      end
   endgenerate

   assign load_val = long_sel ? data_in
                              : {data_in[SHORT_W-1:0], {PAD_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (load)  sr_q <= load_val;
      else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
   end

   assign msb = sr_q[W-1];

   // R9
   sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && !$past(shift)) |-> $stable(msb));

endmodule

// File: rtl/rsp3w_read_tx.sv
module rsp3w_read_tx
   import rsp3w_pkg::*;
#(
   parameter int                     SYNC_STAGES = 2,
   parameter int                     CMD_W       = 8,
   parameter int                     REPLY_W     = 24,
   parameter int                     SHORT_W     = 8,
   parameter int                     N_SHORT     = 10,
   parameter logic [N_SHORT*CMD_W-1:0] SHORT_CODES =
      {8'h05, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'hDA, 8'hDB, 8'hDC},
   parameter logic [CMD_W-1:0]       LONG_CODE   = 8'h04,
   parameter int                     LONG_DUMMY  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sclk,
   input  logic               sdi,
   input  logic               edge_sel,
   input  logic [REPLY_W-1:0] rd_data,
   output logic [CMD_W-1:0]   rd_cmd,
   output logic               rd_req,
   output logic               sdo,
   output logic               sdo_oe
);

   localparam int FRAME_BITS = CMD_W + 1;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam int LEFT_W     = $clog2(REPLY_W);
   localparam int DUM_W      = (LONG_DUMMY > 0) ? $clog2(LONG_DUMMY + 1) : 1;

   generate
      if (LONG_DUMMY < 0) begin : g_bad_dummy
         $error("rsp3w_read_tx: LONG_DUMMY must not be negative");
      end
      if (CMD_W < 2) begin : g_bad_cmd
         $error("rsp3w_read_tx: CMD_W too small");
      end
   endgenerate

   logic             cs_s, sclk_s, sdi_s;
   logic             smp_edge, drv_edge;
   logic             is_short, is_long, hit;
   logic             sr_msb, sr_load, sr_shift;
   rsp_state_e       state_q;
   logic [CMD_W:0]   frame_q;
   logic [CNT_W-1:0] bit_cnt_q;
   logic [LEFT_W-1:0] left_q;
   logic [DUM_W-1:0] wait_q;
   logic             oe_q;

   rsp3w_sync #(
      .STAGES (SYNC_STAGES),
      .W      (3),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({cs_n, sclk, sdi}),
      .dout ({cs_s, sclk_s, sdi_s})
   );

   rsp3w_edges u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .edge_sel(edge_sel),
      .smp_edge(smp_edge),
      .drv_edge(drv_edge)
   );

   rsp3w_decode #(
      .CMD_W      (CMD_W),
      .N_SHORT    (N_SHORT),
      .SHORT_CODES(SHORT_CODES),
      .LONG_CODE  (LONG_CODE)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (frame_q[CMD_W-1:0]),
      .is_short(is_short),
      .is_long (is_long)
   );

   assign hit      = ~frame_q[CMD_W] & (is_short | is_long);
   assign sr_load  = (state_q == ST_DECODE) && hit;
   assign sr_shift = (state_q == ST_SHIFT) && drv_edge && (left_q != '0) && !cs_s;

   rsp3w_shifter #(
      .W      (REPLY_W),
      .SHORT_W(SHORT_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sr_load),
      .long_sel(is_long),
      .data_in (rd_data),
      .shift   (sr_shift),
      .msb     (sr_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_CMD;
         frame_q   <= '0;
         bit_cnt_q <= '0;
         left_q    <= '0;
         wait_q    <= '0;
         oe_q      <= 1'b0;
      end else if (cs_s) begin
         state_q   <= ST_CMD;
         bit_cnt_q <= '0;
         oe_q      <= 1'b0;
      end else begin
         unique case (state_q)
            ST_CMD: begin
               if (smp_edge) begin
                  frame_q <= {frame_q[CMD_W-1:0], sdi_s};
                  if (bit_cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                     bit_cnt_q <= '0;
                     state_q   <= ST_DECODE;
                  end else begin
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end
               end
            end
            ST_DECODE: begin
               if (hit) begin
                  left_q  <= is_long ? LEFT_W'(REPLY_W - 1) : LEFT_W'(SHORT_W - 1);
                  wait_q  <= is_long ? DUM_W'(LONG_DUMMY) : '0;
                  state_q <= ST_WAIT;
               end else begin
                  state_q <= ST_CMD;
               end
            end
            ST_WAIT: begin
               if (drv_edge) begin
                  if (wait_q == '0) begin
                     oe_q    <= 1'b1;
                     state_q <= ST_SHIFT;
                  end else begin
                     wait_q <= wait_q - 1'b1;
                  end
               end
            end
            ST_SHIFT: begin
               if (drv_edge) begin
                  if (left_q == '0) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_DONE;
                  end else begin
                     left_q <= left_q - 1'b1;
                  end
               end
            end
            ST_DONE: begin
               oe_q <= 1'b0;
            end
            default: state_q <= ST_CMD;
         endcase
      end
   end

   assign rd_cmd = frame_q[CMD_W-1:0];
   assign rd_req = (state_q == ST_DECODE);
   assign sdo_oe = oe_q;
   assign sdo    = oe_q & sr_msb;

   // R1
   cs_idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !sdo_oe);

   // R5
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && $past(sdo_oe) && !$past(drv_edge)) |-> $stable(sdo));

   // R6
   oe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(drv_edge));

   // R6
   oe_off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdo_oe) |-> ($past(drv_edge) || $past(cs_s)));

   // R7
   no_req_while_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !sdo_oe);

endmodule

// File: tb/tb_rsp3w_read_tx.sv
module tb_rsp3w_read_tx;

   localparam int HALF = 8;

   typedef struct {
      logic  oe;
      logic  d;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic        edge_sel = 1'b0;
   logic        corrupt = 1'b0;
   logic [23:0] rd_data;
   logic [7:0]  rd_cmd;
   logic        rd_req;
   logic        sdo, sdo_oe;

   int n_cmp = 0;
   int n_bad = 0;
   exp_t sb_q[$];
   event smp_ev;

   always #4 clk = ~clk;

   function automatic logic [23:0] model(input logic [7:0] c);
      return {c ^ 8'hA5, c, ~c};
   endfunction

   assign rd_data = corrupt ? 24'h000000 : model(rd_cmd);

   rsp3w_read_tx dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .edge_sel(edge_sel), .rd_data(rd_data), .rd_cmd(rd_cmd),
      .rd_req(rd_req), .sdo(sdo), .sdo_oe(sdo_oe)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: pops one expectation per host sampling point
   initial begin
      forever begin
         @(smp_ev);
         if (sb_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual empty queue expected item");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(sdo_oe, e.oe, {e.tag, " oe"});
            if (e.oe) chk(sdo, e.d, {e.tag, " data"});
         end
      end
   end

   task automatic half();
      repeat (HALF) @(negedge clk);
   endtask

   // one serial period: drive edge, then sampling point, then sampling edge
   task automatic period(input logic dv, input logic oe_e, input logic d_e, input string tag);
      exp_t e;
      sclk = edge_sel;
      sdi  = dv;
      half();
      e.oe = oe_e; e.d = d_e; e.tag = tag;
      sb_q.push_back(e);
      -> smp_ev;
      #1;
      sclk = ~edge_sel;
      half();
   endtask

   task automatic sel_on();
      sclk = ~edge_sel;
      half();
      cs_n = 1'b0;
      half();
   endtask

   task automatic sel_off();
      half();
      cs_n = 1'b1;
      half(); half();
   endtask

   // R2 frame: flag then code bits MSB first
   task automatic send_frame(input logic flag, input logic [7:0] code);
      period(flag, 1'b0, 1'b0, "R2");
      for (int i = 7; i >= 0; i--) period(code[i], 1'b0, 1'b0, "R2");
   endtask

   task automatic read_reply(input logic [7:0] code, input int nbits, input int ndummy, input string tag);
      logic [23:0] w;
      w = model(code);
      send_frame(1'b0, code);
      for (int k = 0; k < ndummy; k++) period(1'b0, 1'b0, 1'b0, "R4");
      for (int i = nbits - 1; i >= 0; i--) period(1'b0, 1'b1, w[i], tag);
      period(1'b0, 1'b0, 1'b0, "R6");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 reset / idle state
      chk(sdo_oe, 1'b0, "R1 reset");
      // R1 clocks with select high are ignored
      for (int i = 0; i < 12; i++) begin
         sclk = ~sclk; sdi = 1'b0; half();
         chk(sdo_oe, 1'b0, "R1 cs high");
      end

      // R3 short reply, rising-edge sampling
      sel_on(); read_reply(8'h0A, 8, 0, "R3"); sel_off();
      sel_on(); read_reply(8'hDC, 8, 0, "R3"); sel_off();
      // R4 long reply with dummy period
      sel_on(); read_reply(8'h04, 24, 1, "R4"); sel_off();

      // R7 flag=1 with read code, then write code, then a read in the same select
      sel_on();
      send_frame(1'b1, 8'h0A);
      send_frame(1'b0, 8'h2C);
      read_reply(8'hDA, 8, 0, "R7");
      sel_off();

      // R8 abort in mid reply
      sel_on();
      send_frame(1'b0, 8'h04);
      period(1'b0, 1'b0, 1'b0, "R4");
      for (int i = 23; i >= 19; i--) period(1'b0, 1'b1, model(8'h04)[i], "R8");
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(sdo_oe, 1'b0, "R8 abort");
      half();
      sel_on(); read_reply(8'h05, 8, 0, "R8"); sel_off();

      // R9 source changes after decode
      sel_on();
      send_frame(1'b0, 8'h04);
      corrupt = 1'b1;
      period(1'b0, 1'b0, 1'b0, "R4");
      for (int i = 23; i >= 0; i--) period(1'b0, 1'b1, model(8'h04)[i], "R9");
      period(1'b0, 1'b0, 1'b0, "R6");
      sel_off();
      corrupt = 1'b0;

      // R2 R5 opposite mode: sample on falling edge
      edge_sel = 1'b1;
      half();
      sel_on(); read_reply(8'h0F, 8, 0, "R5"); sel_off();
      sel_on(); read_reply(8'h04, 24, 1, "R2"); sel_off();
      edge_sel = 1'b0;

      // R6 stays off after reply until select rises
      sel_on();
      read_reply(8'h0B, 8, 0, "R3");
      for (int i = 0; i < 3; i++) period(1'b0, 1'b0, 1'b0, "R6");
      sel_off();

      half();
      if (sb_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule